// File: doc/BRIEF.md
# Checkpointed Register File with Poison Tracking

This block is the integer register file of a small core that can run ahead speculatively while a long-latency miss is outstanding. Each entry pairs a data word with an invalid ("poison") flag. A result is marked poisoned when the write asks for it directly, for example for a bogus load result. It is also marked poisoned when it depends on a source operand that came back poisoned on a read port. Dependent instructions therefore inherit the mark, and the core can tell which speculative values are untrustworthy.

A shadow copy keeps one data word per architectural register. In normal mode every write lands in both the working entry and the shadow entry in the same cycle, so entering speculation takes no copy cycles: the core just raises the mode input. In speculative mode only the working entries change. When the core leaves speculation it pulses the restore strobe. In that single cycle every working entry is reloaded from the shadow copy and every poison flag is cleared.

The block has two read ports with registered outputs and a write-first bypass. Register 0 always reads as zero, is never poisoned, and ignores writes.

Top module: `spec_regfile`

## Requirements
- R1: After synchronous reset, every entry holds zero and is not poisoned, and both read ports output data 0 and poison 0.
- R2: Each read port registers its result. The data and poison seen on a port in a cycle are those of the entry whose address was presented at the previous rising edge.
- R3: A read of the entry being written at the same edge, without restore, returns the new data and the new poison value.
- R4: The stored poison of a write is wr_poison OR (wr_dep_a AND rd_poison_a) OR (wr_dep_b AND rd_poison_b). The rd_poison values used are the port outputs visible in the write cycle.
- R5: Register 0 reads data 0 with poison 0 at all times, and writes to it, poisoned or not, have no effect.
- R6: A write with spec_mode low updates the working entry and the shadow entry at the same edge, so its value survives a later restore.
- R7: A write with spec_mode high changes only the working entry. It is visible on the read ports until a restore, after which the entry reverts to the last value written with spec_mode low.
- R8: A restore pulse reloads every working entry from the shadow copy and clears every poison flag in one cycle. A read presented in the restore cycle returns the shadow data with poison 0.
- R9: A write presented in the same cycle as restore is discarded, and neither the working copy nor the shadow copy changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_mode | input | 1 | 1 = speculative mode (shadow copy frozen) |
| restore | input | 1 | One-cycle strobe: reload from the shadow copy, clear poison |
| rd_addr_a | input | 4 | Read port A address |
| rd_data_a | output | 32 | Read port A data (registered) |
| rd_poison_a | output | 1 | Read port A poison flag (registered) |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | 32 | Read port B data (registered) |
| rd_poison_b | output | 1 | Read port B poison flag (registered) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| wr_poison | input | 1 | Force the written result poisoned |
| wr_dep_a | input | 1 | Result depends on the operand now on port A |
| wr_dep_b | input | 1 | Result depends on the operand now on port B |

## Verification
Random traffic mixes reads, writes, mode changes and rare restores, and each output is compared against a bench model. This shows whether the shadow copy follows only normal-mode writes. Directed sequences cover the following cases:
- A direct poison, then a dependent write through each port, then a dependent write with clean operands. This separates correct poison propagation from a stuck or ignored dependency.
- A normal write, then a speculative overwrite, then a restore. This separates parallel shadow writes from a shadow copy that follows every write or none.
- Restore colliding with a write, a same-address read and write, and register 0 writes. These expose wrong priority, a missing bypass and a writable zero register.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_NREG  = 16;
  localparam int unsigned RF_WIDTH = 32;
endpackage

// File: rtl/rf_poison_calc.sv
module rf_poison_calc (
  input  logic wr_poison,
  input  logic dep_a,
  input  logic dep_b,
  input  logic src_poison_a,
  input  logic src_poison_b,
  output logic poison_eff
);
  always_comb begin
    poison_eff = wr_poison | (dep_a & src_poison_a) | (dep_b & src_poison_b);
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned NREG  = rf_pkg::RF_NREG,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        spec_mode,
  input  logic                        restore,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  input  logic                        wr_poison,
  output logic [NREG-1:0][WIDTH-1:0]  work_data,
  output logic [NREG-1:0]             work_poison,
  output logic [NREG-1:0][WIDTH-1:0]  ckpt_data
);
  assign work_data[0]   = '0;
  assign work_poison[0] = 1'b0;
  assign ckpt_data[0]   = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(i)) && !restore;

    always_ff @(posedge clk) begin
      if (rst) begin
        work_data[i]   <= '0;
        work_poison[i] <= 1'b0;
        ckpt_data[i]   <= '0;
      end else if (restore) begin
        work_data[i]   <= ckpt_data[i];
        work_poison[i] <= 1'b0;
      end else if (hit) begin
        work_data[i]   <= wr_data;
        work_poison[i] <= wr_poison;
        if (!spec_mode) ckpt_data[i] <= wr_data;
      end
    end
  end

  // R7: shadow copy frozen while speculating
  a_r7_ckpt_hold: assert property (@(posedge clk) disable iff (rst)
    $past(spec_mode && !restore && !rst) |-> ckpt_data == $past(ckpt_data));

  // R8: restore clears every poison flag
  a_r8_poison_clear: assert property (@(posedge clk) disable iff (rst)
    $past(restore && !rst) |-> work_poison == '0);

  // R6: normal-mode write lands in the shadow copy
  a_r6_ckpt_follow: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !spec_mode && !restore && !rst && wr_addr != '0)
      |-> ckpt_data[$past(wr_addr)] == $past(wr_data));

  // R9: restore wins over a same-cycle write
  a_r9_restore_prio: assert property (@(posedge clk) disable iff (rst)
    $past(restore && !rst) |-> work_data == $past(ckpt_data));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NREG  = rf_pkg::RF_NREG,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restore,
  input  logic [AW-1:0]               addr,
  input  logic [NREG-1:0][WIDTH-1:0]  work_data,
  input  logic [NREG-1:0]             work_poison,
  input  logic [NREG-1:0][WIDTH-1:0]  ckpt_data,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  input  logic                        wr_poison,
  output logic [WIDTH-1:0]            rd_data,
  output logic                        rd_poison
);
  logic bypass;
  assign bypass = wr_en && (wr_addr == addr) && !restore;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_poison <= 1'b0;
    end else if (addr == '0) begin
      rd_data   <= '0;
      rd_poison <= 1'b0;
    end else if (restore) begin
      rd_data   <= ckpt_data[addr];
      rd_poison <= 1'b0;
    end else if (bypass) begin
      rd_data   <= wr_data;
      rd_poison <= wr_poison;
    end else begin
      rd_data   <= work_data[addr];
      rd_poison <= work_poison[addr];
    end
  end

  // R5: register 0 reads clean zero
  a_r5_zero_read: assert property (@(posedge clk) disable iff (rst)
    $past(addr == '0) |-> (rd_data == '0 && !rd_poison));

  // R3: same-cycle write is forwarded
  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !restore && !rst && wr_addr == addr && addr != '0)
      |-> rd_data == $past(wr_data));
endmodule

// File: rtl/spec_regfile.sv
module spec_regfile #(
  parameter int unsigned NREG  = rf_pkg::RF_NREG,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spec_mode,
  input  logic             restore,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  output logic             rd_poison_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b,
  output logic             rd_poison_b,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_poison,
  input  logic             wr_dep_a,
  input  logic             wr_dep_b
);
  logic [NREG-1:0][WIDTH-1:0] work_data;
  logic [NREG-1:0]            work_poison;
  logic [NREG-1:0][WIDTH-1:0] ckpt_data;
  logic                       poison_eff;

  logic [1:0][AW-1:0]    port_addr;
  logic [1:0][WIDTH-1:0] port_data;
  logic [1:0]            port_poison;

  rf_poison_calc u_pcalc (
    .wr_poison    (wr_poison),
    .dep_a        (wr_dep_a),
    .dep_b        (wr_dep_b),
    .src_poison_a (rd_poison_a),
    .src_poison_b (rd_poison_b),
    .poison_eff   (poison_eff)
  );

  rf_bank #(.NREG(NREG), .WIDTH(WIDTH)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .spec_mode   (spec_mode),
    .restore     (restore),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_poison   (poison_eff),
    .work_data   (work_data),
    .work_poison (work_poison),
    .ckpt_data   (ckpt_data)
  );

  assign port_addr[0] = rd_addr_a;
  assign port_addr[1] = rd_addr_b;

  for (genvar p = 0; p < 2; p++) begin : g_port
    rf_read_port #(.NREG(NREG), .WIDTH(WIDTH)) u_rd (
      .clk         (clk),
      .rst         (rst),
      .restore     (restore),
      .addr        (port_addr[p]),
      .work_data   (work_data),
      .work_poison (work_poison),
      .ckpt_data   (ckpt_data),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_poison   (poison_eff),
      .rd_data     (port_data[p]),
      .rd_poison   (port_poison[p])
    );
  end

  assign rd_data_a   = port_data[0];
  assign rd_poison_a = port_poison[0];
  assign rd_data_b   = port_data[1];
  assign rd_poison_b = port_poison[1];

  // R4: a dependency on a poisoned operand poisons the result
  a_r4_dep_a: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !restore && !rst && wr_addr != '0 && wr_dep_a && rd_poison_a)
      |-> work_poison[$past(wr_addr)]);

  a_r4_dep_b: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !restore && !rst && wr_addr != '0 && wr_dep_b && rd_poison_b)
      |-> work_poison[$past(wr_addr)]);

  // R4: all-clean inputs leave the result clean
  a_r4_clean: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !restore && !rst && wr_addr != '0 && !wr_poison && !wr_dep_a && !wr_dep_b)
      |-> !work_poison[$past(wr_addr)]);
endmodule

// File: tb/sim_spec_regfile.sv
module sim_spec_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spec_mode = 1'b0, restore = 1'b0;
  logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        rd_poison_a, rd_poison_b;
  logic        wr_en = 1'b0, wr_poison = 1'b0, wr_dep_a = 1'b0, wr_dep_b = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_work [16];
  logic        m_pois [16];
  logic [31:0] m_ckpt [16];
  logic [31:0] e_da = '0, e_db = '0;
  logic        e_pa = 1'b0, e_pb = 1'b0;

  always #4 clk = ~clk;

  spec_regfile u0 (
    .clk(clk), .rst(rst), .spec_mode(spec_mode), .restore(restore),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_poison_a(rd_poison_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .rd_poison_b(rd_poison_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_poison(wr_poison),
    .wr_dep_a(wr_dep_a), .wr_dep_b(wr_dep_b)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=expired expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic new_poison();
    return wr_poison | (wr_dep_a & e_pa) | (wr_dep_b & e_pb);
  endfunction

  function automatic logic [32:0] read_exp(input logic [3:0] a, input logic pe);
    if (a == 0) return 33'd0;
    if (restore) return {1'b0, m_ckpt[a]};
    if (wr_en && wr_addr == a) return {pe, wr_data};
    return {m_pois[a], m_work[a]};
  endfunction

  function automatic string auto_tag(input logic [3:0] a);
    if (a == 0) return "R5";
    if (restore) return "R8";
    if (wr_en && wr_addr == a) return "R3";
    return "R2";
  endfunction

  // one clock: inputs already driven; compare outputs after the edge
  task automatic step(input string tag);
    logic pe;
    logic [32:0] na, nb;
    string ta, tb;
    pe = new_poison();
    na = read_exp(rd_addr_a, pe);
    nb = read_exp(rd_addr_b, pe);
    ta = (tag == "") ? auto_tag(rd_addr_a) : tag;
    tb = (tag == "") ? auto_tag(rd_addr_b) : tag;
    if (restore) begin
      for (int i = 0; i < 16; i++) begin
        m_work[i] = m_ckpt[i];
        m_pois[i] = 1'b0;
      end
    end else if (wr_en && wr_addr != 0) begin
      m_work[wr_addr] = wr_data;
      m_pois[wr_addr] = pe;
      if (!spec_mode) m_ckpt[wr_addr] = wr_data;
    end
    @(posedge clk); #1;
    chk({ta, " port A"}, {rd_poison_a, rd_data_a}, na);
    chk({tb, " port B"}, {rd_poison_b, rd_data_b}, nb);
    {e_pa, e_da} = na;
    {e_pb, e_db} = nb;
  endtask

  task automatic idle();
    wr_en = 0; wr_poison = 0; wr_dep_a = 0; wr_dep_b = 0; restore = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p,
                    input logic da, input logic db);
    wr_en = 1; wr_addr = a; wr_data = d; wr_poison = p; wr_dep_a = da; wr_dep_b = db;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_work[i] = '0; m_pois[i] = 1'b0; m_ckpt[i] = '0;
    end
    void'($urandom(32'd1234));
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    chk("R1 reset port A", {rd_poison_a, rd_data_a}, 33'd0);
    chk("R1 reset port B", {rd_poison_b, rd_data_b}, 33'd0);
    rd_addr_a = 4'd7; rd_addr_b = 4'd15;
    step("R1");

    // R4: direct poison, then dependents
    wr(4'd3, 32'hAAAA_0003, 1, 0, 0); rd_addr_a = 4'd3; rd_addr_b = 4'd2;
    step("R3");
    idle(); step("R4");
    wr(4'd4, 32'h4, 0, 1, 0); step("R4");
    idle(); rd_addr_a = 4'd4; step("R4");
    wr(4'd5, 32'h5, 0, 0, 1); rd_addr_a = 4'd2; rd_addr_b = 4'd3; step("R4");
    idle(); step("R4");
    wr(4'd6, 32'h6, 0, 0, 1); rd_addr_b = 4'd5; step("R4");
    idle(); rd_addr_a = 4'd5; rd_addr_b = 4'd6; step("R4");
    wr(4'd7, 32'h7, 0, 1, 1); rd_addr_a = 4'd2; rd_addr_b = 4'd1; step("R4");
    idle(); rd_addr_a = 4'd7; step("R4");

    // R5: register 0 ignores writes
    wr(4'd0, 32'hDEAD_BEEF, 1, 0, 0); rd_addr_a = 4'd0; step("R5");
    idle(); step("R5");

    // R6 / R7 / R8: normal write, speculative overwrite, restore
    wr(4'd9, 32'h1111_1111, 0, 0, 0); step("R6");
    spec_mode = 1; wr(4'd9, 32'h2222_2222, 1, 0, 0); step("R7");
    idle(); rd_addr_a = 4'd9; rd_addr_b = 4'd3; step("R7");
    restore = 1; spec_mode = 0; step("R8");
    idle(); step("R6");

    // R9: restore collides with a write
    spec_mode = 1; wr(4'd10, 32'h3333, 0, 0, 0); step("R7");
    spec_mode = 0; restore = 1; wr(4'd10, 32'h4444, 1, 0, 0);
    rd_addr_a = 4'd1; step("R9");
    idle(); rd_addr_a = 4'd10; step("R9");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      rd_addr_a = 4'($urandom_range(0, 15));
      rd_addr_b = 4'($urandom_range(0, 15));
      wr_en     = ($urandom_range(0, 3) != 0);
      wr_addr   = ($urandom_range(0, 3) == 0) ? rd_addr_a : 4'($urandom_range(0, 15));
      wr_data   = $urandom;
      wr_poison = ($urandom_range(0, 7) == 0);
      wr_dep_a  = $urandom_range(0, 1) == 1;
      wr_dep_b  = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) spec_mode = ~spec_mode;
      restore   = spec_mode && ($urandom_range(0, 23) == 0);
      step(spec_mode ? "" : "");
      if (restore) spec_mode = 0;
    end
    idle();
    step("");

    summary();
    $finish;
  end
endmodule